// File: doc/BRIEF.md
# Polarity-Configurable Serial Slave Port

This block is the slave side of a serial port for a data converter. An external master supplies a serial clock and an active-low frame strobe. The block moves 16-bit words both ways. Every external pin is first brought into the fast system clock through a synchronizer, and the clock and strobe edges are then detected as single-cycle events. A polarity input chooses which serial clock edge captures incoming bits and which edge moves the next outgoing bit onto the data pin. When the strobe falls, the block can put the first (most significant) outgoing bit on the pin at once. Whether it does depends on the serial clock level at that moment and on the polarity.

A two-bit mode selector and a control bit choose how the port behaves. The default code 00 gives a full-duplex three-wire port with separate data-in and data-out pins. The same code with the control bit set gives a two-wire half-duplex port. In that mode the data-in pin is also the output and is driven through an enable. Code 01 gives the port driven by an external clock and external frame strobe, which is full duplex. Any code with the upper bit set leaves the port idle. Raising the strobe at any time abandons the frame in progress.

Received words leave on a valid/ready stream through a one-entry holding register. Once valid rises, it stays high and the data stays unchanged until ready is seen. A word that completes while the holding register is still full is dropped, because the serial master cannot be stalled. Words to transmit are taken from a second valid/ready stream, and only on the cycle the block sees the strobe fall. If no word is offered at that moment, the frame sends zeros.

Top module: `ssp_slave_port`

## Requirements
- R1: After reset, both output enables, `rx_valid_o` and `tx_ready_o` are low.
- R2: With `pol_i` = 1, input bits are captured on rising serial clock edges and output bits change on falling edges. With `pol_i` = 0, both edges are swapped. Bits go out and come in most significant first.
- R3: On a strobe fall, the most significant output bit appears at once if the serial clock is low with `pol_i` = 1, or high with `pol_i` = 0. Otherwise it appears on the first launching edge.
- R4: A high strobe clears the internal shift state. A frame cut short leaves nothing behind, and the next frame starts a fresh 16-bit word.
- R5: A received word is delivered only when 16 bits were captured before the strobe rose. Capture edges after the 16th in the same frame are ignored.
- R6: `rx_valid_o` stays high and `rx_data_o` stays stable until `rx_ready_i` is seen high. A word that completes while the holding register is full is discarded.
- R7: `tx_ready_o` is high for exactly the one cycle in which the strobe fall is detected, and only when `tx_valid_i` is high and the port is not idle. That cycle is the transfer. A frame that starts without a transfer sends all zeros.
- R8: Mode code 00 with `two_wire_en_i` = 0 is full duplex. `dout_oe_o` is high during the frame, and `dio_oe_o` stays low.
- R9: Mode code 00 with `two_wire_en_i` = 1 is half duplex on the shared pin. A frame that starts with a transmit transfer drives its bits on `dio_o` with `dio_oe_o` high and captures nothing. Any other frame leaves both enables low and receives.
- R10: Mode code 01 is full duplex like R8. Codes 10 and 11 leave the port idle: no enable, no capture, no transmit transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pol_i | input | 1 | Edge polarity select, latched at frame start |
| mode_sel_i | input | 2 | Mode code, latched at frame start |
| two_wire_en_i | input | 1 | Control bit choosing the two-wire variant of code 00 |
| sclk_i | input | 1 | Serial clock from the master |
| sync_n_i | input | 1 | Active-low frame strobe from the master |
| din_i | input | 1 | Serial data in; in two-wire mode this is the shared pin as seen from outside |
| dout_o | output | 1 | Serial data out |
| dout_oe_o | output | 1 | Drive enable for `dout_o` |
| dio_o | output | 1 | Output value for the shared data pin in two-wire mode |
| dio_oe_o | output | 1 | Drive enable for the shared data pin |
| tx_data_i | input | WORD_W | Word to transmit |
| tx_valid_i | input | 1 | Transmit word offered |
| tx_ready_o | output | 1 | Transmit word taken this cycle |
| rx_data_o | output | WORD_W | Received word |
| rx_valid_o | output | 1 | Received word available |
| rx_ready_i | input | 1 | Consumer accepts the received word |

## Verification
If the bit counter or the shift register were left holding state after a strobe rise, it would show up in the next full frame. That word would arrive on `rx_data_o` with bits mixed in from the aborted frame, or one launching edge too early or late on `dout_o`, within 16 serial clock periods. A wrong latched polarity or a wrong early-launch decision shows on the very first sampled bit of the frame. A wrong mode decode shows as a mistaken enable on the first bit, or as a word that appears or goes missing when the strobe rises. An error in the holding register shows as a word that changes while `rx_ready_i` is low, or as the second of two back-to-back words arriving when it should have been dropped.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  typedef enum logic [1:0] {
    PM_OFF      = 2'd0,
    PM_DUPLEX   = 2'd1,
    PM_TWO_WIRE = 2'd2
  } port_mode_e;

  // Mode pins plus the control bit map to one of three behaviours.
  function automatic port_mode_e decode_mode(input logic [1:0] sel,
                                             input logic two_wire);
    port_mode_e m;
    if (sel == 2'b00) m = two_wire ? PM_TWO_WIRE : PM_DUPLEX;
    else if (sel == 2'b01) m = PM_DUPLEX;
    else m = PM_OFF;
    return m;
  endfunction

endpackage

// File: rtl/ssp_pin_sync.sv
module ssp_pin_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] synced_o,
  output logic [N-1:0] prev_o
);
  logic [N-1:0] stage_q [STAGES];
  logic [N-1:0] prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= RESET_VAL;
          else        stage_q[g] <= raw_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= RESET_VAL;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  // One more register gives the previous value for edge detection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RESET_VAL;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign synced_o = stage_q[STAGES-1];
  assign prev_o   = prev_q;
endmodule

// File: rtl/ssp_tx_shifter.sv
module ssp_tx_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         load_i,
  input  logic         launch_i,
  input  logic [W-1:0] load_word_i,
  output logic         bit_o
);
  logic [W-1:0] sh_q;
  logic         bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      bit_q <= 1'b0;
    end else if (clear_i) begin
      sh_q  <= '0;
      bit_q <= 1'b0;
    end else if (load_i) begin
      if (launch_i) begin
        // The MSB goes out in the same cycle the word is loaded.
        {bit_q, sh_q} <= {load_word_i, 1'b0};
      end else begin
        sh_q  <= load_word_i;
        bit_q <= 1'b0;
      end
    end else if (launch_i) begin
      {bit_q, sh_q} <= {sh_q, 1'b0};
    end
  end

  assign bit_o = bit_q;
endmodule

// File: rtl/ssp_rx_shifter.sv
module ssp_rx_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         capture_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o,
  output logic         done_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic [CW-1:0] FULL = CW'(W);

  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (clear_i) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (capture_i && cnt_q != FULL) begin
        sh_q  <= {sh_q[W-2:0], bit_i};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) done_q <= 1'b1;
      end
    end
  end

  assign word_o = sh_q;
  assign done_o = done_q;
endmodule

// File: rtl/ssp_rx_hold.sv
module ssp_rx_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] push_word_i,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  input  logic         ready_i
);
  logic         valid_q;
  logic [W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (push_i && (!valid_q || ready_i)) begin
      valid_q <= 1'b1;
      data_q  <= push_word_i;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
endmodule

// File: rtl/ssp_slave_port.sv
module ssp_slave_port
  import ssp_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pol_i,
  input  logic [1:0]        mode_sel_i,
  input  logic              two_wire_en_i,
  input  logic              sclk_i,
  input  logic              sync_n_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic              dio_o,
  output logic              dio_oe_o,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i
);
  // Pin order inside the synchronizer vector: {din, sync_n, sclk}.
  localparam int PIN_N = 3;
  localparam logic [PIN_N-1:0] PIN_RST = 3'b010;

  logic [PIN_N-1:0] pins_s, pins_p;
  logic s_sclk, p_sclk, s_sync_n, p_sync_n, s_din;

  ssp_pin_sync #(.N(PIN_N), .STAGES(SYNC_STAGES), .RESET_VAL(PIN_RST)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_i    ({din_i, sync_n_i, sclk_i}),
    .synced_o (pins_s),
    .prev_o   (pins_p)
  );

  assign s_sclk   = pins_s[0];
  assign p_sclk   = pins_p[0];
  assign s_sync_n = pins_s[1];
  assign p_sync_n = pins_p[1];
  assign s_din    = pins_s[2];

  logic sync_fall, sclk_rise, sclk_fall;
  assign sync_fall = p_sync_n & ~s_sync_n;
  assign sclk_rise = ~p_sclk & s_sclk;
  assign sclk_fall = p_sclk & ~s_sclk;

  port_mode_e mode_now, mode_q;
  logic frame_act_q, pol_q, read_q;
  logic start, early;

  assign mode_now = decode_mode(mode_sel_i, two_wire_en_i);
  assign start    = sync_fall & (mode_now != PM_OFF);
  // Early MSB: the clock rests on the level that comes before a capture edge.
  assign early    = start & (pol_i ? ~s_sclk : s_sclk);
  assign tx_ready_o = start & tx_valid_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_act_q <= 1'b0;
      mode_q      <= PM_OFF;
      pol_q       <= 1'b0;
      read_q      <= 1'b0;
    end else if (s_sync_n) begin
      frame_act_q <= 1'b0;
      mode_q      <= PM_OFF;
      read_q      <= 1'b0;
    end else if (start) begin
      frame_act_q <= 1'b1;
      mode_q      <= mode_now;
      pol_q       <= pol_i;
      read_q      <= (mode_now == PM_TWO_WIRE) & tx_valid_i;
    end
  end

  logic launch_edge, capture_edge, rx_en, tx_bit;
  assign launch_edge  = frame_act_q & (pol_q ? sclk_fall : sclk_rise);
  assign capture_edge = frame_act_q & (pol_q ? sclk_rise : sclk_fall);
  assign rx_en = capture_edge &
                 ((mode_q == PM_DUPLEX) | ((mode_q == PM_TWO_WIRE) & ~read_q));

  ssp_tx_shifter #(.W(WORD_W)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (s_sync_n),
    .load_i      (start),
    .launch_i    (start ? early : launch_edge),
    .load_word_i (tx_valid_i ? tx_data_i : '0),
    .bit_o       (tx_bit)
  );

  logic [WORD_W-1:0] rx_word;
  logic              rx_done;

  ssp_rx_shifter #(.W(WORD_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (s_sync_n),
    .capture_i (rx_en),
    .bit_i     (s_din),
    .word_o    (rx_word),
    .done_o    (rx_done)
  );

  ssp_rx_hold #(.W(WORD_W)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (rx_done),
    .push_word_i (rx_word),
    .valid_o     (rx_valid_o),
    .data_o      (rx_data_o),
    .ready_i     (rx_ready_i)
  );

  assign dout_o    = tx_bit;
  assign dio_o     = tx_bit;
  assign dout_oe_o = frame_act_q & (mode_q == PM_DUPLEX);
  assign dio_oe_o  = frame_act_q & (mode_q == PM_TWO_WIRE) & read_q;
endmodule

// File: rtl/ssp_slave_port_chk.sv
module ssp_slave_port_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_valid_i,
  input logic              tx_ready_o,
  input logic              rx_valid_o,
  input logic              rx_ready_i,
  input logic [WORD_W-1:0] rx_data_o,
  input logic              dout_oe_o,
  input logic              dio_oe_o
);
  // R8
  oe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dout_oe_o && dio_oe_o));

  // R6
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));

  // R7
  tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready_o |=> !tx_ready_o);

  // R7
  tx_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready_o |-> tx_valid_i);
endmodule

bind ssp_slave_port ssp_slave_port_chk #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_valid_i (tx_valid_i),
  .tx_ready_o (tx_ready_o),
  .rx_valid_o (rx_valid_o),
  .rx_ready_i (rx_ready_i),
  .rx_data_o  (rx_data_o),
  .dout_oe_o  (dout_oe_o),
  .dio_oe_o   (dio_oe_o)
);

// File: tb/sim_ssp_slave_port.sv
module sim_ssp_slave_port;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pol = 1'b1;
  logic [1:0] mode_sel = 2'b00;
  logic two_wire_en = 1'b0;
  logic sclk = 1'b0, sync_n = 1'b1, din = 1'b0;
  logic dout, dout_oe, dio, dio_oe;
  logic [15:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic tx_ready;
  logic [15:0] rx_data;
  logic rx_valid;
  logic rx_ready = 1'b1;

  int checks = 0, errors = 0, tx_takes = 0;
  logic [15:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ssp_slave_port u0 (
    .clk(clk), .rst_n(rst_n), .pol_i(pol), .mode_sel_i(mode_sel),
    .two_wire_en_i(two_wire_en), .sclk_i(sclk), .sync_n_i(sync_n),
    .din_i(din), .dout_o(dout), .dout_oe_o(dout_oe), .dio_o(dio),
    .dio_oe_o(dio_oe), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .rx_ready_i(rx_ready)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Monitor: pops the scoreboard on every receive handshake.
  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected word", {16'h0, rx_data}, 32'h0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(rx_data == e, "R2 received word", {16'h0, rx_data}, {16'h0, e});
      end
    end
    if (rst_n && tx_ready) tx_takes++;
  end

  // chk_pin: 0 none, 1 dout full duplex, 2 dio read frame, 3 no drive expected
  task automatic run_frame(input logic pol_v, input logic early_v,
                           input logic [15:0] mosi, input int nbits,
                           input logic [15:0] miso, input int chk_pin,
                           input string req);
    pol = pol_v;
    sclk = early_v ? ~pol_v : pol_v;
    wait_cyc(H);
    sync_n = 1'b0;
    wait_cyc(H);
    if (!early_v) begin
      sclk = ~sclk;
      wait_cyc(H);
    end
    for (int i = 0; i < nbits; i++) begin
      din = (i < 16) ? mosi[15-i] : 1'b1;
      wait_cyc(H);
      if (chk_pin == 1 || chk_pin == 2) begin
        logic a, e;
        a = (chk_pin == 1) ? dout : dio;
        e = (i < 16) ? miso[15-i] : 1'b0;
        check(a == e, req, {31'h0, a}, {31'h0, e});
      end
      if (i == 0) begin
        check(dout_oe == (chk_pin == 1), "R8 dout enable", {31'h0, dout_oe},
              {31'h0, chk_pin == 1});
        check(dio_oe == (chk_pin == 2), "R9 dio enable", {31'h0, dio_oe},
              {31'h0, chk_pin == 2});
      end
      sclk = ~sclk;
      wait_cyc(H);
      sclk = ~sclk;
      wait_cyc(H);
    end
    sync_n = 1'b1;
    wait_cyc(2*H);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t0;
    wait_cyc(4);
    check(!dout_oe && !dio_oe && !rx_valid && !tx_ready, "R1 reset state",
          {28'h0, dout_oe, dio_oe, rx_valid, tx_ready}, 32'h0);
    rst_n = 1'b1;
    wait_cyc(4);
    check(!dout_oe && !dio_oe && !rx_valid, "R1 idle after reset",
          {29'h0, dout_oe, dio_oe, rx_valid}, 32'h0);

    // R2 R3: polarity high, clock resting low gives an early MSB
    t0 = tx_takes;
    tx_data = 16'hA5C3; tx_valid = 1'b1;
    exp_q.push_back(16'h1234);
    run_frame(1'b1, 1'b1, 16'h1234, 16, 16'hA5C3, 1, "R3 early msb pol1");
    check(tx_takes == t0 + 1, "R7 one transfer", tx_takes - t0, 1);

    // R2: polarity high, MSB waits for the first falling edge
    tx_data = 16'h0F0F;
    exp_q.push_back(16'hBEEF);
    run_frame(1'b1, 1'b0, 16'hBEEF, 16, 16'h0F0F, 1, "R2 late msb pol1");

    // R2 R3: polarity low, clock resting high gives an early MSB
    tx_data = 16'h8001;
    exp_q.push_back(16'h7FFE);
    run_frame(1'b0, 1'b1, 16'h7FFE, 16, 16'h8001, 1, "R3 early msb pol0");

    // R7: no word offered sends zeros
    tx_valid = 1'b0;
    t0 = tx_takes;
    exp_q.push_back(16'h0001);
    run_frame(1'b0, 1'b0, 16'h0001, 16, 16'h0000, 1, "R7 zeros when idle");
    check(tx_takes == t0, "R7 no transfer", tx_takes - t0, 0);

    // R4 R5: an aborted frame leaves nothing, the next one is clean
    run_frame(1'b1, 1'b1, 16'hFFFF, 10, 16'h0000, 1, "R4 partial frame");
    check(!rx_valid && exp_q.size() == 0, "R5 no word from partial",
          {31'h0, rx_valid}, 32'h0);
    exp_q.push_back(16'h00F0);
    run_frame(1'b1, 1'b1, 16'h00F0, 16, 16'h0000, 1, "R4 fresh frame");

    // R5: extra capture edges ignored
    exp_q.push_back(16'h3C3C);
    run_frame(1'b1, 1'b0, 16'h3C3C, 18, 16'h0000, 1, "R5 overlong frame");

    // R10: mode code 01 full duplex
    mode_sel = 2'b01;
    tx_data = 16'h55AA; tx_valid = 1'b1;
    exp_q.push_back(16'hAA55);
    run_frame(1'b1, 1'b1, 16'hAA55, 16, 16'h55AA, 1, "R10 code 01 duplex");

    // R9: two-wire read frame then write frame
    mode_sel = 2'b00; two_wire_en = 1'b1;
    tx_data = 16'hC0DE; tx_valid = 1'b1;
    run_frame(1'b1, 1'b1, 16'h0000, 16, 16'hC0DE, 2, "R9 read frame on dio");
    check(!rx_valid && exp_q.size() == 0, "R9 read frame captures nothing",
          {31'h0, rx_valid}, 32'h0);
    tx_valid = 1'b0;
    exp_q.push_back(16'h1357);
    run_frame(1'b0, 1'b1, 16'h1357, 16, 16'h0000, 3, "R9 write frame");
    two_wire_en = 1'b0;

    // R10: idle codes ignore the frame
    mode_sel = 2'b10;
    tx_data = 16'h9999; tx_valid = 1'b1;
    t0 = tx_takes;
    run_frame(1'b1, 1'b1, 16'h2468, 16, 16'h0000, 3, "R10 idle code");
    check(tx_takes == t0, "R10 no transfer when idle", tx_takes - t0, 0);
    check(!rx_valid, "R10 no word when idle", {31'h0, rx_valid}, 32'h0);
    mode_sel = 2'b00; tx_valid = 1'b0;

    // R6: back-pressure holds the first word and drops the second
    rx_ready = 1'b0;
    run_frame(1'b1, 1'b1, 16'h1111, 16, 16'h0000, 1, "R6 first word");
    run_frame(1'b1, 1'b1, 16'h2222, 16, 16'h0000, 1, "R6 second word");
    check(rx_valid == 1'b1, "R6 valid held", {31'h0, rx_valid}, 32'h1);
    check(rx_data == 16'h1111, "R6 first word kept", {16'h0, rx_data}, 32'h1111);
    exp_q.push_back(16'h1111);
    rx_ready = 1'b1;
    wait_cyc(8);
    check(!rx_valid, "R6 second word dropped", {31'h0, rx_valid}, 32'h0);

    wait_cyc(8);
    check(exp_q.size() == 0, "R5 all expected words seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule